// File: doc/BRIEF.md
# Keypad Autosleep and Autowake Power Controller

This block decides whether a keypad scanning controller is operating or asleep. While the controller is operating, an idle timer counts millisecond ticks during which no key is down. When the count reaches the idle time chosen by a 3-bit timeout code, the block puts the controller to sleep. The timeout code selects a power-of-two number of ticks, and code 0 turns automatic sleep off. Any key activity restarts the count. Writing a new timeout code also restarts it.

Software controls sleep through a configuration write that carries a run bit and an autowake-enable bit. A run bit of 0 forces sleep. A run bit of 1 wakes the block. The run status can always be read back. While asleep, the matrix analog enable is off. When autowake is enabled, a key press during sleep turns the analog enable back on. After a fixed warm-up number of ticks, the block raises a scan-ready flag so the scanner can start debouncing the key that is still held. The block never discards stored key data, so the waking key is not lost. It only gates when scanning may start.

The tick input is a one-cycle pulse every millisecond, produced outside the block. The idle and warm-up times are counted in these ticks.

Top module: `pwr_sleep_ctrl`

## Requirements
- R1: After reset the block is operating: run_stat=1, analog_en=1 and scan_ready=1. The timeout code reads back as 3'b111 and autowake is enabled.
- R2: A timeout code c from 1 to 6 selects an idle time of 2^(BASE_LOG2+6-c) ticks, and code 7 selects the same time as code 6. With BASE_LOG2=8 this gives 8192, 4096, 2048, 1024, 512, 256 and 256 ms. The block leaves operating mode on the edge that samples the last idle tick with no key down.
- R3: Timeout code 3'b000 disables automatic sleep for any number of idle ticks.
- R4: Any cycle with key_active=1 restarts the idle count. A held key keeps the block operating.
- R5: A timeout write whose code differs from the stored code restarts the idle count. Rewriting the same code does not restart it.
- R6: A configuration write with cfg_run=0 puts the block to sleep on the next edge from any state. In sleep, run_stat=0, analog_en=0 and scan_ready=0.
- R7: A configuration write with cfg_run=1 while asleep starts warm-up on the next edge: run_stat=1, analog_en=1 and scan_ready=0.
- R8: While asleep with autowake enabled, key_active=1 starts warm-up on the next edge, with the same outputs as in R7.
- R9: While asleep with autowake disabled (cfg_autowake=0 at the last configuration write), key activity and ticks leave the block asleep.
- R10: During warm-up, scan_ready rises on the edge that samples the WAKE_TICKS-th tick since warm-up began. Key activity does not change this.
- R11: A configuration write takes priority over idle expiry and over autowake in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_run | input | 1 | Run bit written: 0 sleep, 1 operate |
| cfg_autowake | input | 1 | Autowake enable bit written |
| tmo_wr | input | 1 | Timeout code write strobe |
| tmo_code | input | 3 | Timeout code written |
| key_active | input | 1 | High while any key is down |
| tick_1ms | input | 1 | One-cycle millisecond tick pulse |
| run_stat | output | 1 | Readable run status: 1 operating or warming, 0 asleep |
| analog_en | output | 1 | Matrix current source enable |
| scan_ready | output | 1 | Scanner may debounce keys |
| tmo_code_rd | output | 3 | Stored timeout code |

## Verification
The bench builds the block with BASE_LOG2=2 and WAKE_TICKS=3. With these values the longest idle time is 128 ticks instead of 8192, so every timeout code can be run to expiry, and checked one tick short of expiry, inside a short run. Three warm-up ticks leave room to check both scan_ready low and scan_ready high between wake and scan start. The same bench also covers the priority collisions between configuration writes, idle expiry and autowake.

// File: rtl/pwr_pkg.sv
// Shared types and helpers for the keypad sleep controller.
// Assumes timeout codes are 3 bits wide and that code 7 aliases code 6.
package pwr_pkg;

    typedef enum logic [1:0] {
        PS_RUN   = 2'd0,
        PS_WARM  = 2'd1,
        PS_SLEEP = 2'd2
    } pwr_state_t;

    localparam int unsigned CODE_W   = 3;
    localparam int unsigned CODE_SPAN = 6;

    // Log2 of the idle time in ticks for a nonzero timeout code.
    function automatic int unsigned idle_exp(input logic [CODE_W-1:0] code,
                                             input int unsigned base_log2);
        int unsigned c;
        c = (int'(code) > CODE_SPAN) ? CODE_SPAN : int'(code);
        return base_log2 + CODE_SPAN - c;
    endfunction

endpackage

// File: rtl/pwr_cfg_regs.sv
// Holds the autowake enable and the timeout code.
// Also produces a restart pulse when a timeout write changes the stored code.
// Assumes write strobes are single-cycle and synchronous to clk.
module pwr_cfg_regs
    import pwr_pkg::*;
#(
    parameter logic [CODE_W-1:0] TMO_RESET = 3'b111
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic              cfg_autowake,
    input  logic              tmo_wr,
    input  logic [CODE_W-1:0] tmo_code,
    output logic              aw_q,
    output logic [CODE_W-1:0] code_q,
    output logic              restart
);

    // Restart only when the written code differs from the stored one.
    always_comb begin
        restart = tmo_wr && (tmo_code != code_q);
    end

    // Store the autowake bit on configuration writes.
    always_ff @(posedge clk) begin
        if (!rst_n)      aw_q <= 1'b1;
        else if (cfg_wr) aw_q <= cfg_autowake;
    end

    // Store the timeout code on timeout writes.
    always_ff @(posedge clk) begin
        if (!rst_n)      code_q <= TMO_RESET;
        else if (tmo_wr) code_q <= tmo_code;
    end

endmodule

// File: rtl/pwr_idle_timer.sv
// Counts idle ticks while operating.
// Raises expire on the tick that completes the idle time chosen by the code.
// Assumes tick is a one-cycle pulse. Code 0 means the timer never expires.
module pwr_idle_timer
    import pwr_pkg::*;
#(
    parameter int unsigned BASE_LOG2 = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              key_active,
    input  logic              restart,
    input  logic              tick,
    input  logic [CODE_W-1:0] code,
    output logic              expire
);

    localparam int unsigned CNT_W = BASE_LOG2 + CODE_SPAN;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim_m1;
    logic             armed;

    // Last count value before expiry for the current code.
    always_comb begin
        lim_m1 = (CNT_W'(1) << idle_exp(code, BASE_LOG2)) - CNT_W'(1);
    end

    // Decide whether this tick completes the idle time.
    always_comb begin
        armed  = enable && (code != '0) && !key_active && !restart;
        expire = armed && tick && (cnt == lim_m1);
    end

    // Count idle ticks, clearing on activity, restart, expiry or when not operating.
    always_ff @(posedge clk) begin
        if (!rst_n)                    cnt <= '0;
        else if (!armed || expire)     cnt <= '0;
        else if (tick)                 cnt <= cnt + CNT_W'(1);
    end

endmodule

// File: rtl/pwr_warm_timer.sv
// Counts the warm-up ticks between analog enable and scan start.
// Assumes WAKE_TICKS >= 1 and tick is a one-cycle pulse.
module pwr_warm_timer #(
    parameter int unsigned WAKE_TICKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic tick,
    output logic done
);

    localparam int unsigned W = (WAKE_TICKS < 2) ? 1 : $clog2(WAKE_TICKS);

    logic [W-1:0] cnt;

    // Warm-up is complete on the final tick.
    always_comb begin
        done = active && tick && (cnt == W'(WAKE_TICKS - 1));
    end

    // Count ticks while warming, otherwise hold at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt <= '0;
        else if (!active || done) cnt <= '0;
        else if (tick)           cnt <= cnt + W'(1);
    end

endmodule

// File: rtl/pwr_sleep_ctrl.sv
// Top level of the keypad autosleep and autowake controller.
// A three-state machine (run, warm, sleep) is driven by configuration writes,
// idle-timer expiry and key activity. Sleep gates only the analog enable and
// scan start, so stored key data is never touched.
// Assumes synchronous inputs and a one-cycle millisecond tick.
module pwr_sleep_ctrl
    import pwr_pkg::*;
#(
    parameter int unsigned       BASE_LOG2  = 8,
    parameter int unsigned       WAKE_TICKS = 2,
    parameter logic [2:0]        TMO_RESET  = 3'b111
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_wr,
    input  logic       cfg_run,
    input  logic       cfg_autowake,
    input  logic       tmo_wr,
    input  logic [2:0] tmo_code,
    input  logic       key_active,
    input  logic       tick_1ms,
    output logic       run_stat,
    output logic       analog_en,
    output logic       scan_ready,
    output logic [2:0] tmo_code_rd
);

    pwr_state_t state_q, state_d;
    logic       aw_q;
    logic       restart;
    logic       expire;
    logic       warm_done;

    pwr_cfg_regs #(.TMO_RESET(TMO_RESET)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_wr       (cfg_wr),
        .cfg_autowake (cfg_autowake),
        .tmo_wr       (tmo_wr),
        .tmo_code     (tmo_code),
        .aw_q         (aw_q),
        .code_q       (tmo_code_rd),
        .restart      (restart)
    );

    pwr_idle_timer #(.BASE_LOG2(BASE_LOG2)) u_idle (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (state_q == PS_RUN),
        .key_active (key_active),
        .restart    (restart),
        .tick       (tick_1ms),
        .code       (tmo_code_rd),
        .expire     (expire)
    );

    pwr_warm_timer #(.WAKE_TICKS(WAKE_TICKS)) u_warm (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (state_q == PS_WARM),
        .tick   (tick_1ms),
        .done   (warm_done)
    );

    // Next-state logic: configuration writes first, then timers and autowake.
    always_comb begin
        state_d = state_q;
        if (cfg_wr) begin
            if (!cfg_run)                 state_d = PS_SLEEP;
            else if (state_q == PS_SLEEP) state_d = PS_WARM;
        end else begin
            unique case (state_q)
                PS_RUN:   if (expire)              state_d = PS_SLEEP;
                PS_SLEEP: if (aw_q && key_active)  state_d = PS_WARM;
                PS_WARM:  if (warm_done)           state_d = PS_RUN;
                default:                           state_d = PS_SLEEP;
            endcase
        end
    end

    // State register, operating after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PS_RUN;
        else        state_q <= state_d;
    end

    // Output decode from the registered state.
    always_comb begin
        run_stat   = (state_q != PS_SLEEP);
        analog_en  = (state_q != PS_SLEEP);
        scan_ready = (state_q == PS_RUN);
    end

endmodule

// File: rtl/pwr_sleep_ctrl_chk.sv
// Assertion checker for pwr_sleep_ctrl, attached by bind.
module pwr_sleep_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic cfg_wr,
    input logic cfg_run,
    input logic key_active,
    input logic aw_q,
    input logic run_stat,
    input logic analog_en,
    input logic scan_ready
);

    assert_force_sleep_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr && !cfg_run |=> !run_stat && !analog_en && !scan_ready);

    assert_sw_wake_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr && cfg_run && !run_stat |=> run_stat && analog_en && !scan_ready);

    assert_autowake_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !run_stat && !cfg_wr && aw_q && key_active |=> run_stat && !scan_ready);

    assert_no_wake_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !run_stat && !cfg_wr && !aw_q |=> !run_stat);

    assert_key_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
        scan_ready && key_active && !cfg_wr |=> scan_ready);

    assert_scan_after_warm_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scan_ready) |-> $past(analog_en) && !cfg_wr || $past(cfg_wr));

endmodule

bind pwr_sleep_ctrl pwr_sleep_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_wr     (cfg_wr),
    .cfg_run    (cfg_run),
    .key_active (key_active),
    .aw_q       (aw_q),
    .run_stat   (run_stat),
    .analog_en  (analog_en),
    .scan_ready (scan_ready)
);

// File: tb/sim_pwr_sleep_ctrl.sv
module sim_pwr_sleep_ctrl;

    localparam int BASE = 2;
    localparam int WT   = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0, cfg_run = 1'b1, cfg_autowake = 1'b1;
    logic       tmo_wr = 1'b0;
    logic [2:0] tmo_code = 3'd0;
    logic       key_active = 1'b0, tick_1ms = 1'b0;
    logic       run_stat, analog_en, scan_ready;
    logic [2:0] tmo_code_rd;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // Idle-time table for BASE=2: code and expected ticks to sleep.
    localparam int NV = 7;
    localparam int VCODE [NV] = '{1, 2, 3, 4, 5, 6, 7};
    localparam int VTICK [NV] = '{128, 64, 32, 16, 8, 4, 4};

    pwr_sleep_ctrl #(.BASE_LOG2(BASE), .WAKE_TICKS(WT)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_run(cfg_run),
        .cfg_autowake(cfg_autowake), .tmo_wr(tmo_wr), .tmo_code(tmo_code),
        .key_active(key_active), .tick_1ms(tick_1ms), .run_stat(run_stat),
        .analog_en(analog_en), .scan_ready(scan_ready), .tmo_code_rd(tmo_code_rd)
    );

    always #5 clk = ~clk;

    // Watchdog: counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Check run_stat, analog_en, scan_ready together as a 3-bit value.
    task automatic chk_out(input string req, input int exp);
        chk(req, {run_stat, analog_en, scan_ready}, exp);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick_1ms = 1'b1; @(negedge clk);
            tick_1ms = 1'b0; @(negedge clk);
        end
    endtask

    task automatic cfg(input logic run, input logic aw);
        cfg_wr = 1'b1; cfg_run = run; cfg_autowake = aw; @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic set_tmo(input int code);
        tmo_wr = 1'b1; tmo_code = 3'(code); @(negedge clk);
        tmo_wr = 1'b0;
    endtask

    task automatic key_pulse;
        key_active = 1'b1; @(negedge clk);
        key_active = 1'b0;
    endtask

    task automatic wake_full;
        cfg(1'b1, 1'b1);
        ticks(WT);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk_out("R1 outputs", 3'b111);
        chk("R1 code", tmo_code_rd, 7);
        ticks(4);
        chk_out("R1 default code 7 sleeps", 3'b000);
        key_pulse();
        chk_out("R1 autowake default on", 3'b110);
        ticks(WT);
        chk_out("R1 warmup done", 3'b111);

        // R2: table of codes against idle times
        for (int v = 0; v < NV; v++) begin
            set_tmo(VCODE[v]);
            key_pulse();
            ticks(VTICK[v] - 1);
            chk_out("R2 one tick short", 3'b111);
            ticks(1);
            chk_out("R2 expired", 3'b000);
            wake_full();
        end

        // R3: code 0 never sleeps
        set_tmo(0);
        ticks(300);
        chk_out("R3 disabled", 3'b111);

        // R4: key activity restarts the count and a held key keeps operating
        set_tmo(6);
        ticks(3);
        key_pulse();
        ticks(3);
        chk_out("R4 restarted", 3'b111);
        ticks(1);
        chk_out("R4 expires after restart", 3'b000);
        wake_full();
        key_active = 1'b1;
        ticks(10);
        chk_out("R4 held key", 3'b111);
        key_active = 1'b0;

        // R5: a changed code restarts the count, the same code does not
        key_pulse();
        ticks(3);
        set_tmo(7);
        ticks(3);
        chk_out("R5 changed code restarts", 3'b111);
        ticks(1);
        chk_out("R5 sleep after restart", 3'b000);
        wake_full();
        ticks(3);
        set_tmo(7);
        ticks(1);
        chk_out("R5 same code no restart", 3'b000);
        wake_full();

        // R6: forced sleep from run and from warm-up
        cfg(1'b0, 1'b1);
        chk_out("R6 from run", 3'b000);
        cfg(1'b1, 1'b1);
        chk_out("R7 sw wake", 3'b110);
        cfg(1'b0, 1'b1);
        chk_out("R6 from warm", 3'b000);

        // R8 and R10: autowake, then warm-up timing with key held
        key_active = 1'b1; @(negedge clk);
        chk_out("R8 autowake", 3'b110);
        ticks(WT - 1);
        chk_out("R10 still warming", 3'b110);
        ticks(1);
        chk_out("R10 scan ready", 3'b111);
        key_active = 1'b0;

        // R9: autowake disabled ignores keys
        cfg(1'b0, 1'b0);
        key_active = 1'b1;
        ticks(5);
        key_active = 1'b0;
        chk_out("R9 keys ignored", 3'b000);
        cfg(1'b1, 1'b1);
        chk_out("R7 wake after R9", 3'b110);
        ticks(WT);

        // R11: a configuration write wins over autowake and over expiry
        cfg(1'b0, 1'b1);
        key_active = 1'b1; cfg_wr = 1'b1; cfg_run = 1'b0; @(negedge clk);
        cfg_wr = 1'b0; key_active = 1'b0;
        chk_out("R11 write beats autowake", 3'b000);
        wake_full();
        set_tmo(6);
        key_pulse();
        ticks(3);
        tick_1ms = 1'b1; cfg_wr = 1'b1; cfg_run = 1'b1; @(negedge clk);
        tick_1ms = 1'b0; cfg_wr = 1'b0;
        chk_out("R11 write beats expiry", 3'b111);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule